// File: doc/BRIEF.md
# Flag Offset Register Loader

This block fills the two offset registers that a FIFO's programmable flags compare against: the almost-empty offset and the almost-full offset. Both are `log2(DEPTH)` bits wide. The loading method is not set by software. Two dual-purpose input pins carry a select code, and the block captures that code at the first write-clock edge after the active-low reset is released.

There are three ways to fill the registers. A preset method writes the same constant (8 or 16) into both registers at once. A parallel method takes two successive port-A write strobes: the first supplies the almost-full offset and the second the almost-empty offset, each taken from the low bits of the data bus. A serial method reuses the select pins after reset, one as an active-low shift enable and the other as the data bit. It shifts a single chain whose first bit lands in the most significant bit of the almost-full offset and whose last bit lands in the least significant bit of the almost-empty offset.

A done output rises when the chosen method has completed. From then on, the registers hold their values until the next reset.

Top module: `flag_offset_loader`

## Requirements
- R1: While `rstN` is low at a clock edge, the edge clears `aeOffset`, `afOffset` and `loadDone` to 0.
- R2: At the first clock edge with `rstN` high after reset, the code {`selEnN`,`selData`} picks the method: 2'b00 serial, 2'b01 preset 16, 2'b10 preset 8, 2'b11 parallel. The pins do not change the method again until the next reset.
- R3: In a preset method, that same edge loads the preset value into both offsets and raises `loadDone`.
- R4: In serial mode, each later edge with `selEnN` low shifts `selData` into a 2·W-bit chain {`afOffset`,`aeOffset`}. The first bit ends in the MSB of `afOffset` and the last bit in the LSB of `aeOffset`. Edges with `selEnN` high shift nothing.
- R5: In serial mode, `loadDone` rises after the edge carrying the 2·W-th shifted bit, and not after any earlier bit.
- R6: Once `loadDone` is high, further shifts and write strobes leave both offsets unchanged, and `loadDone` stays high until reset.
- R7: In parallel mode, the first edge with `portWrite` high loads `afOffset` from `portData[W-1:0]`. The second such edge loads `aeOffset` the same way and raises `loadDone`. Bus bits above W-1 are ignored.
- R8: In parallel mode the serial pins have no effect, and in serial mode `portWrite` has no effect.
- R9: A reset in the middle of a serial or parallel load abandons it. A fresh method is chosen afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rstN | input | 1 | Synchronous active-low reset |
| selEnN | input | 1 | Select bit 1 at reset; active-low serial shift enable afterwards |
| selData | input | 1 | Select bit 0 at reset; serial data bit afterwards |
| portWrite | input | 1 | Port-A write strobe used by the parallel method |
| portData | input | DATA_W | Port-A data bus |
| aeOffset | output | W | Almost-empty offset register |
| afOffset | output | W | Almost-full offset register |
| loadDone | output | 1 | Offsets are complete |

## Verification
Each select code is applied at reset release, so that a wrong decode shows up as the wrong method. The serial chain is driven with random bit streams interleaved with disabled cycles that carry random data. This separates correct shift order and enable gating from bit reversal, a swapped register order, or shifts that leak through. A check one bit before the end separates the exact completion count from an off-by-one, and extra bits after done expose a missing lock. Parallel loads use random full-width words with idle cycles and toggling serial pins, which separates the Y-then-X ordering, truncation of the upper bits and cross-mode isolation.

// File: rtl/flag_offset_pkg.sv
package flag_offset_pkg;

  typedef enum logic [1:0] {
    METHOD_SERIAL   = 2'b00,
    METHOD_PRESETHI = 2'b01,
    METHOD_PRESETLO = 2'b10,
    METHOD_PARALLEL = 2'b11
  } method_e;

  typedef struct packed {
    logic clear;
    logic loadPreset;
    logic presetHigh;
    logic shift;
    logic loadY;
    logic loadX;
  } ofs_strobe_t;

endpackage

// File: rtl/flag_offset_ctrl.sv
module flag_offset_ctrl
  import flag_offset_pkg::*;
#(
  parameter int OFS_W = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        selEnN,
  input  logic        selData,
  input  logic        portWrite,
  output ofs_strobe_t stb,
  output method_e     methodQ,
  output logic        armQ,
  output logic        doneQ
);

  localparam int CHAIN_W = 2 * OFS_W;
  localparam int CNT_W   = $clog2(CHAIN_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(CHAIN_W - 1);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;
  method_e          pinCode;
  logic             active;
  logic             serialStep;
  logic             wordStep;

  assign pinCode    = method_e'({selEnN, selData});
  assign active     = rstN && !armQ && !doneQ;
  assign serialStep = active && (methodQ == METHOD_SERIAL) && !selEnN;
  assign wordStep   = active && (methodQ == METHOD_PARALLEL) && portWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armQ    <= 1'b1;
      methodQ <= METHOD_SERIAL;
      cntQ    <= '0;
      doneQ   <= 1'b0;
    end else if (armQ) begin
      armQ    <= 1'b0;
      methodQ <= pinCode;
      doneQ   <= (pinCode == METHOD_PRESETHI) || (pinCode == METHOD_PRESETLO);
    end else if (serialStep) begin
      cntQ <= cntQ + 1'b1;
      if (cntQ == LAST_BIT) doneQ <= 1'b1;
    end else if (wordStep) begin
      cntQ <= cntQ + 1'b1;
      if (cntQ == LAST_WORD) doneQ <= 1'b1;
    end
  end

  always_comb begin
    stb            = '0;
    stb.clear      = !rstN;
    stb.loadPreset = rstN && armQ &&
                     ((pinCode == METHOD_PRESETHI) || (pinCode == METHOD_PRESETLO));
    stb.presetHigh = (pinCode == METHOD_PRESETHI);
    stb.shift      = serialStep;
    stb.loadY      = wordStep && (cntQ == '0);
    stb.loadX      = wordStep && (cntQ == LAST_WORD);
  end

endmodule

// File: rtl/flag_offset_dpath.sv
module flag_offset_dpath
  import flag_offset_pkg::*;
#(
  parameter int OFS_W     = 11,
  parameter int PRESET_LO = 8,
  parameter int PRESET_HI = 16
) (
  input  logic             clk,
  input  ofs_strobe_t      stb,
  input  logic             serBit,
  input  logic [OFS_W-1:0] busLow,
  output logic [OFS_W-1:0] xQ,
  output logic [OFS_W-1:0] yQ
);

  localparam logic [OFS_W-1:0] VAL_LO = OFS_W'(PRESET_LO);
  localparam logic [OFS_W-1:0] VAL_HI = OFS_W'(PRESET_HI);

  logic [OFS_W-1:0] presetVal;
  assign presetVal = stb.presetHigh ? VAL_HI : VAL_LO;

  always_ff @(posedge clk) begin
    if (stb.clear) begin
      xQ <= '0;
      yQ <= '0;
    end else if (stb.loadPreset) begin
      xQ <= presetVal;
      yQ <= presetVal;
    end else if (stb.shift) begin
      {yQ, xQ} <= {yQ[OFS_W-2:0], xQ, serBit};
    end else if (stb.loadY) begin
      yQ <= busLow;
    end else if (stb.loadX) begin
      xQ <= busLow;
    end
  end

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import flag_offset_pkg::*;
#(
  parameter int DEPTH     = 2048,
  parameter int DATA_W    = 36,
  parameter int PRESET_LO = 8,
  parameter int PRESET_HI = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     selEnN,
  input  logic                     selData,
  input  logic                     portWrite,
  input  logic [DATA_W-1:0]        portData,
  output logic [$clog2(DEPTH)-1:0] aeOffset,
  output logic [$clog2(DEPTH)-1:0] afOffset,
  output logic                     loadDone
);

  localparam int OFS_W = $clog2(DEPTH);

  ofs_strobe_t stb;
  method_e     methodQ;
  logic        armQ;
  logic        unusedBusBits;

  assign unusedBusBits = ^portData[DATA_W-1:OFS_W];

  flag_offset_ctrl #(.OFS_W(OFS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .selEnN(selEnN), .selData(selData),
    .portWrite(portWrite), .stb(stb), .methodQ(methodQ), .armQ(armQ),
    .doneQ(loadDone)
  );

  flag_offset_dpath #(.OFS_W(OFS_W), .PRESET_LO(PRESET_LO), .PRESET_HI(PRESET_HI)) u_dpath (
    .clk(clk), .stb(stb), .serBit(selData), .busLow(portData[OFS_W-1:0]),
    .xQ(aeOffset), .yQ(afOffset)
  );

endmodule

// File: rtl/flag_offset_loader_chk.sv
module flag_offset_loader_chk
  import flag_offset_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int DATA_W = 36
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     selData,
  input logic [DATA_W-1:0]        portData,
  input logic [$clog2(DEPTH)-1:0] aeOffset,
  input logic [$clog2(DEPTH)-1:0] afOffset,
  input logic                     loadDone,
  input ofs_strobe_t              stb
);

  localparam int W = $clog2(DEPTH);

  logic lowQ = 1'b0;
  always_ff @(posedge clk) lowQ <= !rstN;

  // R1: an edge seen in reset leaves everything cleared
  always @(negedge clk)
    if (lowQ) a_r1_reset_clears: assert (aeOffset == '0 && afOffset == '0 && !loadDone);

  // R6: done is sticky until reset
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> loadDone);

  // R6: offsets frozen once done
  a_r6_offsets_frozen: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> ($stable(aeOffset) && $stable(afOffset)));

  // R4: a shift moves the chain by one and inserts the data bit
  a_r4_shift_order: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |=> (aeOffset[0] == $past(selData) &&
                   aeOffset[W-1:1] == $past(aeOffset[W-2:0]) &&
                   afOffset == {$past(afOffset[W-2:0]), $past(aeOffset[W-1])}));

  // R7: the first parallel word lands in the almost-full offset
  a_r7_parallel_y: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadY |=> (afOffset == $past(portData[W-1:0])));

  // R8: at most one load action per edge
  a_r8_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadPreset, stb.shift, stb.loadY, stb.loadX}));

endmodule

bind flag_offset_loader flag_offset_loader_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .selData(selData), .portData(portData),
  .aeOffset(aeOffset), .afOffset(afOffset), .loadDone(loadDone), .stb(stb)
);

// File: tb/tb_flag_offset_loader.sv
module tb_flag_offset_loader;

  localparam int DEPTH  = 2048;
  localparam int DATA_W = 36;
  localparam int W      = $clog2(DEPTH);
  localparam int CHAIN  = 2 * W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selEnN = 1'b1, selData = 1'b0, portWrite = 1'b0;
  logic [DATA_W-1:0] portData = '0;
  logic [W-1:0] aeOffset, afOffset;
  logic loadDone;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  flag_offset_loader #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .selEnN(selEnN), .selData(selData),
    .portWrite(portWrite), .portData(portData),
    .aeOffset(aeOffset), .afOffset(afOffset), .loadDone(loadDone)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [CHAIN-1:0] chainPush(input logic [CHAIN-1:0] c, input logic b);
    return {c[CHAIN-2:0], b};
  endfunction

  function automatic logic [W-1:0] lowBits(input logic [DATA_W-1:0] d);
    return d[W-1:0];
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  // Apply reset for four edges, release with the given select code,
  // then let the arming edge pass.
  task automatic doReset(input logic [1:0] code);
    rstN = 1'b0; selEnN = 1'b1; portWrite = 1'b0;
    repeat (4) step();
    rstN = 1'b1; {selEnN, selData} = code;
    step();
    selEnN = 1'b1; selData = 1'($urandom);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      selEnN = 1'b1; selData = 1'($urandom);
      portWrite = 1'b0; portData = {$urandom, $urandom};
      step();
    end
  endtask

  task automatic shiftBit(input logic b);
    selEnN = 1'b0; selData = b; step();
    selEnN = 1'b1;
  endtask

  task automatic writeWord(input logic [DATA_W-1:0] d);
    portWrite = 1'b1; portData = d; step();
    portWrite = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [CHAIN-1:0] exp;
    logic [DATA_W-1:0] dY, dX;
    void'($urandom(32'h5eed_1234));

    // R1 reset state
    repeat (4) step();
    check("R1 ae", aeOffset, 0);
    check("R1 af", afOffset, 0);
    check("R1 done", loadDone, 0);

    // R2/R3 preset 16
    doReset(2'b01);
    check("R3 preset16 ae", aeOffset, 16);
    check("R3 preset16 af", afOffset, 16);
    check("R3 preset16 done", loadDone, 1);
    // R6 serial bits after done ignored
    shiftBit(1'b1); shiftBit(1'b1);
    check("R6 preset hold ae", aeOffset, 16);

    // R2/R3 preset 8
    doReset(2'b10);
    check("R3 preset8 ae", aeOffset, 8);
    check("R3 preset8 af", afOffset, 8);

    // R1 reset clears prior load
    rstN = 1'b0; step(); step();
    check("R1 clear after load", {afOffset, aeOffset, loadDone}, 0);

    // Serial loads, several random streams
    for (int run = 0; run < 4; run++) begin
      doReset(2'b00);
      check("R2 serial not done", loadDone, 0);
      exp = '0;
      for (int i = 0; i < CHAIN; i++) begin
        logic b;
        b = (run == 0) ? (i == 0) : 1'($urandom);
        exp = chainPush(exp, b);
        idle($urandom_range(0, 2));
        portWrite = 1'b1;  // R8: strobe must not matter in serial mode
        shiftBit(b);
        portWrite = 1'b0;
        if (i == 4) check("R4 partial chain", aeOffset, {{(W-5){1'b0}}, exp[4:0]});
        if (i == CHAIN - 2) check("R5 not done one bit early", loadDone, 0);
      end
      check("R5 done after last bit", loadDone, 1);
      check("R4 af chain", afOffset, exp[CHAIN-1:W]);
      check("R4 ae chain", aeOffset, exp[W-1:0]);
      shiftBit(~exp[0]); shiftBit(1'b1);
      check("R6 extra bits ignored", {afOffset, aeOffset}, exp);
      check("R6 done held", loadDone, 1);
    end

    // R9: reset mid serial, then parallel
    doReset(2'b00);
    for (int i = 0; i < 7; i++) shiftBit(1'b1);
    for (int run = 0; run < 3; run++) begin
      doReset(2'b11);
      dY = {$urandom, $urandom}; dX = {$urandom, $urandom};
      check("R9 fresh after reset", {afOffset, aeOffset, loadDone}, 0);
      idle(2);
      // R8: serial pins toggling must not touch the parallel load
      shiftBit(1'b1); shiftBit(1'b0);
      check("R8 serial ignored in parallel", {afOffset, aeOffset}, 0);
      writeWord(dY);
      check("R7 Y loaded first", afOffset, lowBits(dY));
      check("R7 X untouched", aeOffset, 0);
      check("R7 not done after one", loadDone, 0);
      idle($urandom_range(0, 3));
      writeWord(dX);
      check("R7 X loaded", aeOffset, lowBits(dX));
      check("R7 done", loadDone, 1);
      writeWord(~dX);
      check("R6 third write ignored", {afOffset, aeOffset}, {lowBits(dY), lowBits(dX)});
    end

    // R9: reset between the two parallel words
    doReset(2'b11);
    writeWord(36'h0_0000_0155);
    doReset(2'b01);
    check("R9 new method after abort", {afOffset, aeOffset}, {11'd16, 11'd16});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule